// File: doc/BRIEF.md
# Reconfigurable-Ratio Third-Order CIC Decimator

This block turns a 1-bit sigma-delta bitstream into 14-bit samples at a lower rate. Each accepted bit is mapped to +1 or -1 and fed to three cascaded accumulators running at the input rate. Once every D accepted bits, three cascaded differencing stages update under a clock enable, which keeps them idle for the other D-1 input samples. The result is a third-order sinc (sinc3) decimator.

The ratio D is chosen at run time by a 4-bit code, from 32 up to 2048 in powers of two. A single accumulator width serves every ratio: it is sized for the largest one. A window multiplexer takes the 14 bits that are significant for the active ratio, with their position moving as the ratio changes. A change of code flushes the filter and restarts it cleanly under the new ratio.

Both data paths use valid/ready handshakes. Input bits are accepted when `in_valid` and `in_ready` are both high. An output sample is held on `out_data` with `out_valid` high until `out_ready` is seen high. While an output sample waits, no input is accepted. The ratio code is a plain control pin.

Top module: `cic_decim`

## Requirements
- R1: An accepted input bit of 1 counts as +1 and a bit of 0 as -1. Each output sample equals the sum of the last 3D-2 accepted values weighted by the sinc3 coefficients, which are the convolution of three length-D all-ones windows. The newest bit takes the coefficient at index 0.
- R2: Ratio code k = 0..6 selects D = 32·2^k. Codes 7 to 15 select D = 2048. Two codes that map to the same D are the same setting, so moving between them causes no flush.
- R3: `out_data` is bits [3·log2(D) : 3·log2(D)-13] of the exact two's-complement sum. The single value +2^(3·log2 D) saturates to 14'h1FFF. Negative full scale gives 14'h2000.
- R4: One decimated result is produced per D accepted inputs. `out_valid` rises on the clock edge that accepts the input completing a window.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low. During that time `out_valid` and `out_data` hold their values, unless a ratio change flushes them.
- R6: When the mapped ratio code differs from the active ratio, `in_ready` is low for that cycle. On the following edge all filter state and any pending output are cleared. The new ratio then counts its first window from the next accepted input.
- R7: After reset and after every ratio change, the first three decimated results are suppressed. The fourth is the first to raise `out_valid`.
- R8: After reset the active ratio is code 0 (D = 32) and `out_valid` is low. With code 0 applied and `out_ready` high, `in_ready` is high.
- R9: Cycles in which `in_valid` or `in_ready` is low leave the filter unchanged and do not advance the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input bit is present |
| in_ready | output | 1 | Block accepts an input bit this cycle |
| in_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| ratio_code | input | 4 | Decimation ratio selection |
| out_valid | output | 1 | Decimated sample is present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_data | output | 14 | Decimated sample, two's complement |

## Verification
The hardest case to reach from the ports is the 2048 ratio under full-scale input. It needs three suppressed windows plus a fourth, about 8200 accepted bits, before the saturation corner at the widest window position can be seen at all. The stimulus holds a constant-ones stream for more than six such windows, using an out-of-range code so the clamping is exercised too. A ratio change is also forced while an unaccepted output is pending, to show that the flush drops it. A behavioural reference computes every expected sample as an explicit convolution over a queue of the accepted bits. It tracks the expected handshake state cycle by cycle.

// File: rtl/cic_pkg.sv
package cic_pkg;
  parameter int CIC_ORDER   = 3;   // integrator / comb stage count
  parameter int CIC_LOG_MIN = 5;   // log2 of the smallest ratio
  parameter int CIC_NRATIO  = 7;   // number of selectable ratios
  parameter int CIC_OUT_W   = 14;  // output word width
  parameter int CIC_CODE_W  = 4;   // ratio code width
  parameter int CIC_SKIP    = 3;   // results dropped after a flush
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             in_bit,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc [ORDER];
  logic [ACC_W-1:0] nxt [ORDER];
  logic [ACC_W-1:0] x;

  assign x = in_bit ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign nxt[g] = acc[g] + x;
    end else begin : g_next
      assign nxt[g] = acc[g] + nxt[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc[g] <= '0;
      else if (clr)  acc[g] <= '0;
      else if (en)   acc[g] <= nxt[g];
    end
  end

  assign sum_o = nxt[ORDER-1];
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] dly  [ORDER];
  logic [ACC_W-1:0] src  [ORDER];
  logic [ACC_W-1:0] diff [ORDER];

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign src[g] = din;
    end else begin : g_next
      assign src[g] = diff[g-1];
    end
    assign diff[g] = src[g] - dly[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dly[g] <= '0;
      else if (clr) dly[g] <= '0;
      else if (en)  dly[g] <= src[g];
    end
  end

  assign dout = diff[ORDER-1];
endmodule

// File: rtl/cic_ratio_ctrl.sv
module cic_ratio_ctrl #(
  parameter int LOG_MIN = 5,
  parameter int NRATIO  = 7,
  parameter int CODE_W  = 4,
  parameter int SKIP    = 3,
  localparam int IDX_W  = $clog2(NRATIO),
  localparam int CNT_W  = LOG_MIN + NRATIO - 1,
  localparam int SKIP_W = $clog2(SKIP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              in_valid,
  input  logic              out_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              fire,
  output logic              flush,
  output logic              comb_en,
  output logic              emit,
  output logic [IDX_W-1:0]  act_idx
);
  logic [IDX_W-1:0]  req_idx;
  logic [CNT_W-1:0]  cnt;
  logic [SKIP_W-1:0] skip_cnt;
  logic              last;

  assign req_idx  = (ratio_code > CODE_W'(NRATIO - 1)) ? IDX_W'(NRATIO - 1)
                                                        : ratio_code[IDX_W-1:0];
  assign flush    = (req_idx != act_idx);
  assign in_ready = !flush && !(out_valid && !out_ready);
  assign fire     = in_valid && in_ready;
  assign last     = (cnt == CNT_W'((32'd1 << (LOG_MIN + 32'(act_idx))) - 32'd1));
  assign comb_en  = fire && last;
  assign emit     = comb_en && (skip_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_idx  <= '0;
      cnt      <= '0;
      skip_cnt <= SKIP_W'(SKIP);
    end else if (flush) begin
      act_idx  <= req_idx;
      cnt      <= '0;
      skip_cnt <= SKIP_W'(SKIP);
    end else if (fire) begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last && skip_cnt != '0) skip_cnt <= skip_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cic_window.sv
module cic_window #(
  parameter int ORDER   = 3,
  parameter int LOG_MIN = 5,
  parameter int NRATIO  = 7,
  parameter int OUT_W   = 14,
  parameter int ACC_W   = 35,
  localparam int IDX_W  = $clog2(NRATIO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             emit,
  input  logic             out_ready,
  input  logic [IDX_W-1:0] sel,
  input  logic [ACC_W-1:0] acc_in,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic [OUT_W-1:0] cand [NRATIO];
  logic [NRATIO-1:0] sat;
  logic [OUT_W-1:0] word;

  for (genvar g = 0; g < NRATIO; g++) begin : g_pos
    localparam int TOP = ORDER * (LOG_MIN + g);
    assign cand[g] = acc_in[TOP -: OUT_W];
    assign sat[g]  = (acc_in == (ACC_W'(1) << TOP));
  end

  assign word = sat[sel] ? {1'b0, {(OUT_W-1){1'b1}}} : cand[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int ORDER   = CIC_ORDER,
  parameter int LOG_MIN = CIC_LOG_MIN,
  parameter int NRATIO  = CIC_NRATIO,
  parameter int OUT_W   = CIC_OUT_W,
  parameter int CODE_W  = CIC_CODE_W,
  parameter int SKIP    = CIC_SKIP,
  localparam int LOG_MAX = LOG_MIN + NRATIO - 1,
  localparam int ACC_W   = ORDER * LOG_MAX + 2,
  localparam int IDX_W   = $clog2(NRATIO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data
);
  logic             fire, flush_req, comb_en, emit;
  logic [IDX_W-1:0] act_idx;
  logic [ACC_W-1:0] integ_sum, comb_out;

  cic_ratio_ctrl #(.LOG_MIN(LOG_MIN), .NRATIO(NRATIO), .CODE_W(CODE_W), .SKIP(SKIP)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .in_valid(in_valid),
    .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
    .fire(fire), .flush(flush_req), .comb_en(comb_en), .emit(emit), .act_idx(act_idx)
  );

  cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) integ_i (
    .clk(clk), .rst_n(rst_n), .clr(flush_req), .en(fire), .in_bit(in_bit), .sum_o(integ_sum)
  );

  cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) comb_i (
    .clk(clk), .rst_n(rst_n), .clr(flush_req), .en(comb_en), .din(integ_sum), .dout(comb_out)
  );

  cic_window #(.ORDER(ORDER), .LOG_MIN(LOG_MIN), .NRATIO(NRATIO), .OUT_W(OUT_W), .ACC_W(ACC_W)) win_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_req), .emit(emit), .out_ready(out_ready),
    .sel(act_idx), .acc_in(comb_out), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int OUT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             flush_req
);
  // R5: a waiting output blocks the input side
  p_stall_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5: a waiting output keeps its value
  p_hold_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush_req) |=> (out_valid && $stable(out_data)));

  // R6: no input accepted in the flush cycle
  p_flush_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !in_ready);

  // R6: a flush drops any pending output
  p_flush_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !out_valid);

  // R4: a new output appears only after an accepted input
  p_emit_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind cic_decim cic_decim_chk #(.OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .flush_req(flush_req)
);

// File: tb/cic_decim_tb_top.sv
module cic_decim_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic [3:0] ratio_code = 4'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [13:0] out_data;

  always #5 clk = ~clk;

  cic_decim dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .ratio_code(ratio_code), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R8";
  bit    done = 1'b0;

  // ---------------- reference model ----------------
  longint hcoef [0:3*2048-1];
  longint tri_p [0:2*2048-1];
  int     xq [$];
  int     act_m, cnt_m, supp_m, dlen;
  bit     ev;
  int     ed;

  function automatic int map_code(input int c);
    return (c > 6) ? 6 : c;
  endfunction

  task automatic build_h(input int idx);
    int     d;
    longint run;
    d = 32 << idx;
    dlen = d;
    run = 0;
    for (int k = 0; k <= 2*d-2; k++) begin
      run += ((k + 1) < (2*d - 1 - k)) ? (k + 1) : (2*d - 1 - k);
      tri_p[k] = run;
    end
    for (int j = 0; j <= 3*d-3; j++) begin
      int hi, lo;
      hi = (j < 2*d-2) ? j : 2*d-2;
      lo = (j - d + 1 > 0) ? j - d + 1 : 0;
      hcoef[j] = tri_p[hi] - ((lo > 0) ? tri_p[lo-1] : 64'sd0);
    end
  endtask

  function automatic int to_word(input longint s, input int idx);
    int top;
    longint fs;
    top = 3 * (5 + idx);
    fs = 64'sd1 <<< top;
    if (s == fs) return 14'h1FFF;
    return int'((s >>> (top - 13)) & 64'sh3FFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      act_m = 0; cnt_m = 0; supp_m = 3; ev = 1'b0; ed = 0;
      xq.delete();
      build_h(0);
    end else begin
      int  ni;
      bit  rdy;
      ni = map_code(int'(ratio_code));
      if (ni != act_m) begin
        act_m = ni; cnt_m = 0; supp_m = 3; ev = 1'b0;
        xq.delete();
        build_h(ni);
      end else begin
        rdy = !(ev && !out_ready);
        if (ev && out_ready) ev = 1'b0;
        if (in_valid && rdy) begin
          xq.push_back(in_bit ? 1 : -1);
          if (xq.size() > 3*dlen-2) void'(xq.pop_front());
          cnt_m++;
          if (cnt_m == dlen) begin
            cnt_m = 0;
            if (supp_m > 0) supp_m--;
            else begin
              longint s;
              int n;
              s = 0;
              n = xq.size();
              for (int j = 0; j <= 3*dlen-3; j++) s += hcoef[j] * longint'(xq[n-1-j]);
              ed = to_word(s, act_m);
              ev = 1'b1;
            end
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int pv, input int pr, input int mode);
    bit exp_rdy;
    @(negedge clk);
    check(out_valid == ev, cur_req, "out_valid", int'(out_valid), int'(ev));
    if (ev) check(out_data == 14'(ed), cur_req, "out_data", int'(out_data), ed);
    in_valid  = (($urandom % 100) < pv);
    in_bit    = (mode == 0) ? 1'($urandom % 2) : (mode == 1);
    out_ready = (($urandom % 100) < pr);
    #1;
    exp_rdy = (map_code(int'(ratio_code)) == act_m) && !(ev && !out_ready);
    check(in_ready == exp_rdy, cur_req, "in_ready", int'(in_ready), int'(exp_rdy));
  endtask

  task automatic run(input int n, input int pv, input int pr, input int mode);
    for (int i = 0; i < n; i++) step(pv, pr, mode);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);

    cur_req = "R1"; run(2000, 100, 100, 0);     // random bits, D=32, continuous
    cur_req = "R9"; run(2000, 60, 100, 0);      // input gaps
    cur_req = "R3"; run(400, 100, 100, 1);      // positive full scale
    run(400, 100, 100, 2);                      // negative full scale
    cur_req = "R5"; run(3000, 90, 40, 0);       // back-pressure

    ratio_code = 4'd2;                          // D=128
    cur_req = "R7"; run(600, 100, 100, 0);      // suppression window after change
    cur_req = "R6"; run(1400, 100, 100, 0);

    ratio_code = 4'd9;                          // out of range -> 2048
    cur_req = "R2"; run(13000, 100, 100, 1);    // saturation at widest window
    ratio_code = 4'd6;                          // same ratio, no flush
    run(6200, 100, 100, 0);

    ratio_code = 4'd0;                          // pending output dropped by change
    cur_req = "R6";
    for (int i = 0; i < 600 && !ev; i++) step(100, 0, 0);
    check(ev == 1'b1, "R6", "pending output reached", int'(ev), 1);
    ratio_code = 4'd1;
    run(5, 100, 0, 0);
    run(1000, 100, 100, 0);

    ratio_code = 4'd3;                          // D=256 with gaps
    cur_req = "R4"; run(5000, 80, 100, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule